// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to eight peripheral interrupt events and turns them into one request line and a vector number for a processor core. Software sees four byte-wide ports on a small register bus. The first holds the vector base, the second holds a per-source enable mask and the third reads the pending flags. The fourth is a write-only port: each 1 written to it clears the matching pending flag.

A one-cycle event pulse on a source line sets that source's pending flag, but only when its enable bit is set. This happens even when the processor has interrupts globally off. The controller always selects the highest-numbered pending source whose enable bit is set. It adds that source's index to the base to form the vector number. It raises the request only while the processor's global interrupt flag is on and the processor is not asserting its one-instruction inhibit. A model-select input picks which low bits of the base are dropped when the base is written, and whether reads of the base show the two lowest bits forced high.

Top module: `irqc_top`

## Requirements
- R1: After reset the base, enable mask and pending flags are all zero and `irq_req` is low.
- R2: With `model_sel`=1, a write to the base port (0xB0) keeps data bits 7..3 and clears bits 2..0. A read of 0xB0 in this mode returns the stored base OR 0x03.
- R3: With `model_sel`=0, a write to 0xB0 keeps bits 7..1 and clears bit 0. A read of 0xB0 in this mode returns the stored base unchanged.
- R4: The enable mask at 0xB2 is a plain 8-bit read/write register.
- R5: A 1 on `src_pulse[i]` at a clock edge sets pending bit i, which can be read at 0xB4 after that edge. This happens only if enable bit i was already 1 before that edge, and it does not depend on `cpu_ie`.
- R6: A write to 0xB6 clears every pending bit whose data bit is 1 and leaves the other pending bits unchanged.
- R7: When a source pulse and a clearing write at 0xB6 hit the same bit in the same cycle, that bit ends up set.
- R8: Clearing an enable bit leaves an already-set pending bit set. It also stops that source from setting its pending bit again.
- R9: The selected source is the highest index i where both pending bit i and enable bit i are 1. `vec_num` equals the base plus i, modulo 256.
- R10: `irq_req` is high exactly when at least one bit is both pending and enabled, `cpu_ie` is 1 and `inhibit` is 0, all in the same cycle.
- R11: A read of 0xB6 or of any address other than 0xB0, 0xB2 and 0xB4 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| model_sel | input | 1 | Base masking rule: 1 keeps bits 7..3 and reads back OR 0x03; 0 keeps bits 7..1 |
| bus_addr | input | 8 | Register port address |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| src_pulse | input | 8 | Event pulses, one per source |
| cpu_ie | input | 1 | Processor global interrupt flag |
| inhibit | input | 1 | Holds off the request for the current cycle |
| irq_req | output | 1 | Interrupt request to the processor |
| vec_num | output | 8 | Base plus the index of the selected source |

## Verification
Several properties are checked every cycle. A pending bit never rises without an enabled pulse one cycle earlier, and an enabled pulse always leaves its bit set, even when the same bit is acknowledged in that cycle. Acknowledged bits fall, the base's dropped bits stay zero, the selected index is the highest pending-and-enabled bit, and the request stays low while the processor is inhibited or has interrupts off. Some behaviour can only be shown by the bench's scenarios: the exact read-back values in each model mode, the vector arithmetic including wrap-around at 256, the zero returned by unmapped reads, and a masked source that keeps its old pending flag.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
    localparam int DW   = 8;
    localparam int NSRC = DW;
    localparam int IW   = $clog2(NSRC);

    localparam logic [7:0] OFS_BASE = 8'hB0;
    localparam logic [7:0] OFS_EN   = 8'hB2;
    localparam logic [7:0] OFS_PEND = 8'hB4;
    localparam logic [7:0] OFS_CLR  = 8'hB6;

    localparam logic [DW-1:0] BASE_KEEP_WIDE   = DW'(8'hF8);
    localparam logic [DW-1:0] BASE_KEEP_NARROW = DW'(8'hFE);
    localparam logic [DW-1:0] BASE_RD_FORCE    = DW'(8'h03);

    typedef struct packed {
        logic [DW-1:0]   base;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] pend;
    } irqc_state_t;
endpackage

// File: rtl/irqc_regs.sv
`timescale 1ns/1ps
module irqc_regs
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            model_sel,
    input  logic            bus_wr,
    input  logic [7:0]      bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic [NSRC-1:0] src_pulse,
    output logic [DW-1:0]   base_q,
    output logic [NSRC-1:0] en_q,
    output logic [NSRC-1:0] pend_q
);
    irqc_state_t st_d, st_q;
    logic [NSRC-1:0] set_d, clr_d;

    always_comb begin
        st_d  = st_q;
        clr_d = '0;
        set_d = src_pulse & st_q.en;
        if (bus_wr) begin
            unique case (bus_addr)
                OFS_BASE: st_d.base = bus_wdata &
                    (model_sel ? BASE_KEEP_WIDE : BASE_KEEP_NARROW);
                OFS_EN:   st_d.en   = bus_wdata;
                OFS_CLR:  clr_d     = bus_wdata;
                default:  ;
            endcase
        end
        st_d.pend = (st_q.pend & ~clr_d) | set_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_q = st_q.base;
    assign en_q   = st_q.en;
    assign pend_q = st_q.pend;

    // R5: a pending bit only rises after an enabled pulse
    a_r5_rise_needs_enabled_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q)) & ~$past(src_pulse & en_q)) == '0);
    // R7: an enabled pulse always leaves its bit set, acknowledge or not
    a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(src_pulse & en_q) & ~pend_q) == '0);
    // R6: acknowledged bits without a new pulse are cleared
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && bus_addr == OFS_CLR) |->
        (($past(bus_wdata) & ~$past(src_pulse & en_q)) & pend_q) == '0);
    // R2: wide masking leaves the low three base bits zero
    a_r2_base_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && bus_addr == OFS_BASE && model_sel) |-> base_q[2:0] == 3'b000);
    // R3: base bit 0 is never stored
    a_r3_base_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        base_q[0] == 1'b0);
endmodule

// File: rtl/irqc_prio.sv
`timescale 1ns/1ps
module irqc_prio #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);
    logic [N:0]   above;
    logic [N-1:0] grant;

    assign above[N] = 1'b0;
    for (genvar i = N - 1; i >= 0; i--) begin : g_chain
        assign above[i] = above[i+1] | req[i];
        assign grant[i] = req[i] & ~above[i+1];
    end

    assign valid = above[0];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++)
            if (grant[i]) idx = idx | IW'(i);
    end
endmodule

// File: rtl/irqc_rdmux.sv
`timescale 1ns/1ps
module irqc_rdmux
    import irqc_pkg::*;
(
    input  logic            model_sel,
    input  logic [7:0]      bus_addr,
    input  logic [DW-1:0]   base_q,
    input  logic [NSRC-1:0] en_q,
    input  logic [NSRC-1:0] pend_q,
    output logic [DW-1:0]   bus_rdata
);
    always_comb begin
        unique case (bus_addr)
            OFS_BASE: bus_rdata = model_sel ? (base_q | BASE_RD_FORCE) : base_q;
            OFS_EN:   bus_rdata = en_q;
            OFS_PEND: bus_rdata = pend_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            model_sel,
    input  logic [7:0]      bus_addr,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NSRC-1:0] src_pulse,
    input  logic            cpu_ie,
    input  logic            inhibit,
    output logic            irq_req,
    output logic [DW-1:0]   vec_num
);
    logic [DW-1:0]   base_q;
    logic [NSRC-1:0] en_q, pend_q, live;
    logic            any_live;
    logic [IW-1:0]   sel_idx;

    irqc_regs i_regs (
        .clk(clk), .rst_n(rst_n), .model_sel(model_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .src_pulse(src_pulse),
        .base_q(base_q), .en_q(en_q), .pend_q(pend_q)
    );

    assign live = pend_q & en_q;

    irqc_prio #(.N(NSRC)) i_prio (
        .req(live), .valid(any_live), .idx(sel_idx)
    );

    irqc_rdmux i_rdmux (
        .model_sel(model_sel), .bus_addr(bus_addr), .base_q(base_q),
        .en_q(en_q), .pend_q(pend_q), .bus_rdata(bus_rdata)
    );

    assign vec_num = base_q + DW'(sel_idx);
    assign irq_req = any_live & cpu_ie & ~inhibit;

    // R9: the selected index is the highest live bit
    a_r9_highest_live: assert property (@(posedge clk) disable iff (!rst_n)
        any_live |-> (live >> sel_idx) == NSRC'(1));
    // R10: no request while inhibited
    a_r10_inhibit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> !irq_req);
    // R10: no request while the global flag is off
    a_r10_ie_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ie |-> !irq_req);
    // R8: a request implies some enabled source is pending
    a_r8_req_needs_live: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend_q & en_q) != '0);
endmodule

// File: tb/test_irqc_top.sv
`timescale 1ns/1ps
module test_irqc_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       model_sel = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] src_pulse = 8'h00;
    logic       cpu_ie = 1'b0;
    logic       inhibit = 1'b0;
    logic       irq_req;
    logic [7:0] vec_num;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irqc_top i_irqc_top (
        .clk(clk), .rst_n(rst_n), .model_sel(model_sel), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_pulse(src_pulse), .cpu_ie(cpu_ie), .inhibit(inhibit),
        .irq_req(irq_req), .vec_num(vec_num)
    );

    // {model_sel, write data, expected read-back}
    localparam logic [16:0] BASE_TBL [8] = '{
        {1'b1, 8'hFF, 8'hFB}, {1'b1, 8'h07, 8'h03},
        {1'b1, 8'h48, 8'h4B}, {1'b1, 8'h01, 8'h03},
        {1'b0, 8'hFF, 8'hFE}, {1'b0, 8'h01, 8'h00},
        {1'b0, 8'h37, 8'h36}, {1'b0, 8'h80, 8'h80}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [7:0] s);
        @(negedge clk);
        src_pulse = s;
        @(negedge clk);
        src_pulse = 8'h00;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'hB0, v); check("R1 base", v, 8'h00);
        rd(8'hB2, v); check("R1 enable", v, 8'h00);
        rd(8'hB4, v); check("R1 pending", v, 8'h00);
        check("R1 irq", {7'd0, irq_req}, 8'h00);

        // R2/R3: base masking table
        foreach (BASE_TBL[k]) begin
            @(negedge clk);
            model_sel = BASE_TBL[k][16];
            wr(8'hB0, BASE_TBL[k][15:8]);
            rd(8'hB0, v);
            check(BASE_TBL[k][16] ? "R2 base" : "R3 base", v, BASE_TBL[k][7:0]);
        end
        model_sel = 1'b0;

        // R4: enable register
        wr(8'hB2, 8'h5A); rd(8'hB2, v); check("R4 enable", v, 8'h5A);

        // R5: latching only for enabled sources, with global flag off
        wr(8'hB2, 8'h81);
        pulse(8'hFF);
        rd(8'hB4, v); check("R5 latch", v, 8'h81);
        check("R10 ie off", {7'd0, irq_req}, 8'h00);

        // R9/R10: priority, vector and request gating
        wr(8'hB2, 8'hFF);
        wr(8'hB0, 8'h20);
        check("R9 vector", vec_num, 8'h27);
        cpu_ie = 1'b1; #1;
        check("R10 req", {7'd0, irq_req}, 8'h01);
        inhibit = 1'b1; #1;
        check("R10 inhibit", {7'd0, irq_req}, 8'h00);
        inhibit = 1'b0; #1;

        // R6: write-one-to-clear
        wr(8'hB6, 8'h80);
        rd(8'hB4, v); check("R6 ack", v, 8'h01);
        check("R9 vector low", vec_num, 8'h20);

        // R7: pulse and clear in the same cycle
        @(negedge clk);
        src_pulse = 8'h02; bus_addr = 8'hB6; bus_wdata = 8'h03; bus_wr = 1'b1;
        @(negedge clk);
        src_pulse = 8'h00; bus_wr = 1'b0;
        rd(8'hB4, v); check("R7 set wins", v, 8'h02);

        // R8: masking keeps the flag, blocks relatching
        wr(8'hB2, 8'hFD);
        rd(8'hB4, v); check("R8 kept", v, 8'h02);
        check("R8 no req", {7'd0, irq_req}, 8'h00);
        wr(8'hB6, 8'h02);
        pulse(8'h02);
        rd(8'hB4, v); check("R8 blocked", v, 8'h00);

        // R11: unmapped reads
        rd(8'hB6, v); check("R11 clr port", v, 8'h00);
        rd(8'h10, v); check("R11 unmapped", v, 8'h00);

        // R2/R9: wide mode vector
        model_sel = 1'b1;
        wr(8'hB0, 8'h47);
        rd(8'hB0, v); check("R2 readback", v, 8'h43);
        pulse(8'h0C);
        check("R9 wide vector", vec_num, 8'h43);

        // R9: wrap-around at 256
        wr(8'hB6, 8'hFF);
        model_sel = 1'b0;
        wr(8'hB0, 8'hFE);
        wr(8'hB2, 8'hFF);
        pulse(8'h81);
        check("R9 wrap", vec_num, 8'h05);

        finish_run();
    end
endmodule